// File: doc/BRIEF.md
# UART Register Front End with Receive Queue

This block is the software-facing register layer of a small serial port. A processor reaches it through a 32-bit single-cycle read/write port with byte addresses. It sees four word-spaced registers: receive data, transmit data, status and control. Bytes from a receiver that has already deserialised them enter through a valid/ready pair and wait in an eight-entry queue until software reads them.

A transmit-register write sends its low byte out as a one-cycle strobe. The transmit side never backs up, so the status always shows it as empty and never as full. A level interrupt follows a sticky pending flag, gated by an enable bit in the control register. The error bits in the status word are reserved and read as zero.

The queue occupancy is a three-state machine (`FIFO_EMPTY`, `FIFO_PART`, `FIFO_FULL`).
- Accept-from-empty moves `FIFO_EMPTY` to `FIFO_PART`.
- Fill-last moves `FIFO_PART` to `FIFO_FULL` when a lone push meets seven held bytes.
- Drain-last moves `FIFO_PART` to `FIFO_EMPTY` when a lone pop meets one held byte.
- Unfill moves `FIFO_FULL` to `FIFO_PART` on a pop.
- Flush moves any state to `FIFO_EMPTY`.
- Every other cycle holds the state.

Top module: `uart_regfront`

## Requirements
- R1: The register is selected by address bits [3:2]: 0 receive data, 1 transmit data, 2 status, 3 control. Address bits [1:0] are ignored. Read data is valid in the same cycle as the read request, and side effects take place at the clock edge that ends it.
- R2: The status word is laid out as follows. Bit 0 is receive-data-valid (queue not empty) and bit 1 is queue full. Bit 2 is transmit empty, always 1, and bit 3 is transmit full, always 0. Bit 4 is interrupt pending. Bits 31:5 read 0.
- R3: A control write stores all 32 bits, and they read back unchanged. When bit 1 is set, the queue count and write pointer go to 0, and a byte offered in the same cycle is discarded. Bit 0 has no further effect. Bit 4 is the interrupt enable.
- R4: The queue holds up to 8 bytes and returns them in arrival order.
- R5: rx_ready is high exactly when fewer than 8 bytes are held. A byte offered while 8 are held is dropped, and the contents and count stay unchanged.
- R6: A receive-data read returns the oldest byte in bits 7:0 (upper bits 0) and removes it. A read of an empty queue returns the entry at the write pointer and changes nothing.
- R7: A byte arriving in the same cycle as a receive-data read is accepted, and the count changes by the net effect of both.
- R8: The pending flag is set in any cycle after which the queue holds at least one byte, and by any transmit write. Only reset clears it.
- R9: irq equals pending AND control bit 4, and it follows a register change on the same clock edge.
- R10: A transmit write pulses tx_strobe for exactly one cycle, starting the cycle after the write, with tx_byte equal to write data bits 7:0. The full written word reads back from the transmit register.
- R11: A write to the status register raises bus_err in that same cycle and changes no state.
- R12: After reset the queue is empty with zeroed storage, control reads 0, pending is 0, irq is 0, tx_strobe is 0 and rx_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access request for this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the request cycle |
| bus_err | output | 1 | Error response for an illegal write |
| rx_valid | input | 1 | Received byte offered |
| rx_byte | input | 8 | Received byte |
| rx_ready | output | 1 | Queue can accept a byte |
| tx_strobe | output | 1 | One-cycle transmit pulse |
| tx_byte | output | 8 | Byte to transmit |
| irq | output | 1 | Level interrupt |

## Verification
The properties assume the following about the inputs:
- Each bus request lasts exactly one cycle.
- bus_wr and bus_addr are meaningful only while bus_sel is high.
- A receive byte is offered for one cycle at a time.
- A drop is judged from the offer alone, whichever way rx_ready points.

The directed stimulus drives every input on the falling edge and holds each request for a single cycle. It offers a byte into a full queue on purpose, to exercise the drop path. Simultaneous cases, a push with a pop and a push with a flush, are driven together in one cycle so that the net-effect and priority rules are reached.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;

    typedef enum logic [1:0] {
        REG_RXDATA = 2'd0,
        REG_TXDATA = 2'd1,
        REG_STATUS = 2'd2,
        REG_CTRL   = 2'd3
    } reg_idx_e;

    typedef enum logic [1:0] {
        FIFO_EMPTY = 2'd0,
        FIFO_PART  = 2'd1,
        FIFO_FULL  = 2'd2
    } fifo_state_e;

    localparam int ST_RXVALID = 0;
    localparam int ST_RXFULL  = 1;
    localparam int ST_TXEMPTY = 2;
    localparam int ST_TXFULL  = 3;
    localparam int ST_PEND    = 4;

    localparam int CT_TXRST   = 0;
    localparam int CT_RXFLUSH = 1;
    localparam int CT_IE      = 4;

endpackage

// File: rtl/uart_rf_decode.sv
module uart_rf_decode
    import uart_rf_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    output reg_idx_e          idx_o,
    output logic              rd_rx_o,
    output logic              wr_tx_o,
    output logic              wr_ctrl_o,
    output logic              wr_stat_o
);
    // Word index taken from bits [3:2]; the byte lane bits carry no meaning.
    assign idx_o = reg_idx_e'(addr_i[3:2]);

    always_comb begin
        rd_rx_o   = 1'b0;
        wr_tx_o   = 1'b0;
        wr_ctrl_o = 1'b0;
        wr_stat_o = 1'b0;
        if (sel_i) begin
            unique case (idx_o)
                REG_RXDATA: rd_rx_o   = !wr_i;
                REG_TXDATA: wr_tx_o   = wr_i;
                REG_STATUS: wr_stat_o = wr_i;
                REG_CTRL:   wr_ctrl_o = wr_i;
                default:    ;
            endcase
        end
    end
endmodule

// File: rtl/uart_rf_rxfifo.sv
module uart_rf_rxfifo
    import uart_rf_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int BYTE_W = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [BYTE_W-1:0] push_data_i,
    input  logic              pop_i,
    input  logic              flush_i,
    output logic [BYTE_W-1:0] head_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              nonempty_next_o,
    output fifo_state_e       state_o,
    output logic              ready_o
);
    logic [PTR_W-1:0]  wp_q, wp_d, rd_idx;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [BYTE_W-1:0] mem [DEPTH];
    fifo_state_e       state_q, state_d;
    logic              push_ok, pop_ok;

    // Flush beats both push and pop in the same cycle.
    assign push_ok = push_i && (state_q != FIFO_FULL) && !flush_i;
    assign pop_ok  = pop_i && (cnt_q != '0) && !flush_i;

    // Oldest entry sits count places behind the write pointer.
    assign rd_idx = wp_q - cnt_q[PTR_W-1:0];
    assign head_o = mem[rd_idx];

    always_comb begin
        if (flush_i) begin
            wp_d  = '0;
            cnt_d = '0;
        end else begin
            wp_d  = wp_q + PTR_W'(push_ok);
            cnt_d = cnt_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_slot
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    mem[gi] <= '0;
                end else if (push_ok && (wp_q == PTR_W'(gi))) begin
                    mem[gi] <= push_data_i;
                end
            end
        end
    endgenerate

    // Occupancy state machine: next state.
    always_comb begin
        state_d = state_q;
        if (flush_i) begin
            state_d = FIFO_EMPTY;
        end else begin
            unique case (state_q)
                FIFO_EMPTY: if (push_ok) state_d = FIFO_PART;
                FIFO_PART: begin
                    if (push_ok && !pop_ok && cnt_q == CNT_W'(DEPTH - 1))
                        state_d = FIFO_FULL;
                    else if (pop_ok && !push_ok && cnt_q == CNT_W'(1))
                        state_d = FIFO_EMPTY;
                end
                FIFO_FULL:  if (pop_ok) state_d = FIFO_PART;
                default:    state_d = FIFO_EMPTY;
            endcase
        end
    end

    // Occupancy state machine: state register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FIFO_EMPTY;
            wp_q    <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            wp_q    <= wp_d;
            cnt_q   <= cnt_d;
        end
    end

    // Occupancy state machine: outputs.
    always_comb begin
        ready_o = 1'b1;
        unique case (state_q)
            FIFO_EMPTY: ready_o = 1'b1;
            FIFO_PART:  ready_o = 1'b1;
            FIFO_FULL:  ready_o = 1'b0;
            default:    ready_o = 1'b1;
        endcase
    end

    assign state_o         = state_q;
    assign count_o         = cnt_q;
    assign nonempty_next_o = (cnt_d != '0);
endmodule

// File: rtl/uart_rf_ctrl.sv
module uart_rf_ctrl
    import uart_rf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_tx_i,
    input  logic              wr_ctrl_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              rx_nonempty_next_i,
    output logic [DATA_W-1:0] ctrl_o,
    output logic [DATA_W-1:0] txdata_o,
    output logic              pend_o,
    output logic              tx_strobe_o,
    output logic [BYTE_W-1:0] tx_byte_o,
    output logic              irq_o
);
    logic [DATA_W-1:0] ctrl_q, txdata_q;
    logic              pend_q, strobe_q;
    logic [BYTE_W-1:0] byte_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            txdata_q <= '0;
            pend_q   <= 1'b0;
            strobe_q <= 1'b0;
            byte_q   <= '0;
        end else begin
            strobe_q <= wr_tx_i;
            if (wr_ctrl_i) ctrl_q <= wdata_i;
            if (wr_tx_i) begin
                txdata_q <= wdata_i;
                byte_q   <= wdata_i[BYTE_W-1:0];
            end
            // Sticky: only reset ever lowers it.
            if (wr_tx_i || rx_nonempty_next_i) pend_q <= 1'b1;
        end
    end

    assign ctrl_o      = ctrl_q;
    assign txdata_o    = txdata_q;
    assign pend_o      = pend_q;
    assign tx_strobe_o = strobe_q;
    assign tx_byte_o   = byte_q;
    assign irq_o       = pend_q && ctrl_q[CT_IE];
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
    import uart_rf_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    parameter int DEPTH  = 8,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              rx_ready,
    output logic              tx_strobe,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              irq
);
    reg_idx_e          idx;
    logic              rd_rx, wr_tx, wr_ctrl, wr_stat;
    logic              flush_req;
    logic [BYTE_W-1:0] rx_head;
    logic [CNT_W-1:0]  rx_count;
    logic              rx_nonempty_next;
    fifo_state_e       rx_state;
    logic [DATA_W-1:0] ctrl_val, txdata_val, status_val;
    logic              pend;

    uart_rf_decode #(.ADDR_W(ADDR_W)) u_dec (
        .sel_i     (bus_sel),
        .wr_i      (bus_wr),
        .addr_i    (bus_addr),
        .idx_o     (idx),
        .rd_rx_o   (rd_rx),
        .wr_tx_o   (wr_tx),
        .wr_ctrl_o (wr_ctrl),
        .wr_stat_o (wr_stat)
    );

    assign flush_req = wr_ctrl && bus_wdata[CT_RXFLUSH];

    uart_rf_rxfifo #(.DEPTH(DEPTH), .BYTE_W(BYTE_W)) u_fifo (
        .clk             (clk),
        .rst_n           (rst_n),
        .push_i          (rx_valid),
        .push_data_i     (rx_byte),
        .pop_i           (rd_rx),
        .flush_i         (flush_req),
        .head_o          (rx_head),
        .count_o         (rx_count),
        .nonempty_next_o (rx_nonempty_next),
        .state_o         (rx_state),
        .ready_o         (rx_ready)
    );

    uart_rf_ctrl #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_ctrl (
        .clk                (clk),
        .rst_n              (rst_n),
        .wr_tx_i            (wr_tx),
        .wr_ctrl_i          (wr_ctrl),
        .wdata_i            (bus_wdata),
        .rx_nonempty_next_i (rx_nonempty_next),
        .ctrl_o             (ctrl_val),
        .txdata_o           (txdata_val),
        .pend_o             (pend),
        .tx_strobe_o        (tx_strobe),
        .tx_byte_o          (tx_byte),
        .irq_o              (irq)
    );

    always_comb begin
        status_val             = '0;
        status_val[ST_RXVALID] = (rx_state != FIFO_EMPTY);
        status_val[ST_RXFULL]  = (rx_state == FIFO_FULL);
        status_val[ST_TXEMPTY] = 1'b1;
        status_val[ST_TXFULL]  = 1'b0;
        status_val[ST_PEND]    = pend;
    end

    always_comb begin
        bus_rdata = '0;
        unique case (idx)
            REG_RXDATA: bus_rdata = DATA_W'(rx_head);
            REG_TXDATA: bus_rdata = txdata_val;
            REG_STATUS: bus_rdata = status_val;
            REG_CTRL:   bus_rdata = ctrl_val;
            default:    bus_rdata = '0;
        endcase
    end

    assign bus_err = wr_stat;
endmodule

// File: rtl/uart_rf_chk.sv
module uart_rf_chk
    import uart_rf_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 4,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              bus_err,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic              tx_strobe,
    input logic [7:0]        tx_byte,
    input logic              irq,
    input logic [CNT_W-1:0]  rx_count,
    input fifo_state_e       rx_state,
    input logic              pend,
    input logic [31:0]       ctrl_val
);
    logic is_rd_rx, is_wr_tx, is_wr_st, is_flush;
    assign is_rd_rx = bus_sel && !bus_wr && bus_addr[3:2] == 2'd0;
    assign is_wr_tx = bus_sel && bus_wr && bus_addr[3:2] == 2'd1;
    assign is_wr_st = bus_sel && bus_wr && bus_addr[3:2] == 2'd2;
    assign is_flush = bus_sel && bus_wr && bus_addr[3:2] == 2'd3 && bus_wdata[1];

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count <= CNT_W'(DEPTH));

    p_state_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == '0) == (rx_state == FIFO_EMPTY));

    p_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready == (rx_count < CNT_W'(DEPTH)));

    p_drop_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && rx_count == CNT_W'(DEPTH) && !is_rd_rx && !is_flush
        |=> rx_count == CNT_W'(DEPTH));

    p_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        is_rd_rx && rx_count != '0 && !rx_valid
        |=> rx_count == $past(rx_count) - CNT_W'(1));

    p_flush_r3: assert property (@(posedge clk) disable iff (!rst_n)
        is_flush |=> rx_count == '0);

    p_pend_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pend |=> pend);

    p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> pend && ctrl_val[4]);

    p_tx_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        is_wr_tx |=> tx_strobe && tx_byte == $past(bus_wdata[7:0]));

    p_tx_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !is_wr_tx |=> !tx_strobe);

    p_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
        is_wr_st |-> bus_err);

    p_err_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> is_wr_st);
endmodule

bind uart_regfront uart_rf_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_err   (bus_err),
    .rx_valid  (rx_valid),
    .rx_ready  (rx_ready),
    .tx_strobe (tx_strobe),
    .tx_byte   (tx_byte),
    .irq       (irq),
    .rx_count  (rx_count),
    .rx_state  (rx_state),
    .pend      (pend),
    .ctrl_val  (ctrl_val)
);

// File: tb/tb_uart_regfront.sv
module tb_uart_regfront;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_ready, tx_strobe, irq;
    logic [7:0]  tx_byte;
    int          checks = 0, errors = 0;

    always #5 clk = ~clk;

    uart_regfront dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_ready(rx_ready), .tx_strobe(tx_strobe), .tx_byte(tx_byte), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d, output logic err);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        #2 err = bus_err;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R12 tx_strobe", 32'(tx_strobe), 0);
        check("R12 irq", 32'(irq), 0);
        check("R12 rx_ready", 32'(rx_ready), 1);
        bus_read(4'h8, d); check("R12/R2 status after reset", d, 32'h4);
        bus_read(4'hC, d); check("R12 ctrl after reset", d, 0);
        bus_read(4'h0, d); check("R12 stale entry zero", d, 0);
    endtask

    task automatic t_order();
        logic [31:0] d;
        push(8'h11); push(8'h22); push(8'h33);
        bus_read(4'hA, d); check("R2/R8 status with data", d, 32'h15);
        bus_read(4'h1, d); check("R1/R4 first byte", d, 32'h11);
        bus_read(4'h2, d); check("R4 second byte", d, 32'h22);
        bus_read(4'h3, d); check("R4 third byte", d, 32'h33);
        bus_read(4'h8, d); check("R8 pending sticky when empty", d, 32'h14);
    endtask

    task automatic t_full();
        logic [31:0] d;
        for (int i = 0; i < 8; i++) push(8'hA0 + 8'(i));
        bus_read(4'h8, d); check("R2 status full", d, 32'h17);
        check("R5 ready low when full", 32'(rx_ready), 0);
        push(8'hEE);
        for (int i = 0; i < 8; i++) begin
            bus_read(4'h0, d); check("R5/R4 full drain order", d, 32'hA0 + i);
        end
        // write pointer wrapped back to the slot holding A0
        bus_read(4'h0, d); check("R6 empty read stale", d, 32'hA0);
        bus_read(4'h8, d); check("R6 empty read no change", d, 32'h14);
        check("R5 ready high again", 32'(rx_ready), 1);
    endtask

    task automatic t_simul();
        logic [31:0] d;
        push(8'h55);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = 8'h66;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 4'h0;
        #2 d = bus_rdata;
        @(negedge clk);
        rx_valid = 1'b0; bus_sel = 1'b0;
        check("R7 read during push", d, 32'h55);
        bus_read(4'h0, d); check("R7 pushed byte kept", d, 32'h66);
        bus_read(4'h8, d); check("R7 net count zero", d, 32'h14);
    endtask

    task automatic t_flush();
        logic [31:0] d;
        push(8'h01); push(8'h02);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'hC; bus_wdata = 32'h0000_0002;
        rx_valid = 1'b1; rx_byte = 8'h77;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; rx_valid = 1'b0;
        bus_read(4'h8, d); check("R3 flush empties queue", d, 32'h14);
        bus_read(4'hC, d); check("R3 ctrl readback", d, 32'h2);
        push(8'h88);
        bus_read(4'h0, d); check("R3 queue usable after flush", d, 32'h88);
    endtask

    task automatic t_irq();
        logic e;
        check("R9 irq off while disabled", 32'(irq), 0);
        bus_write(4'hC, 32'h0000_0010, e);
        #1 check("R9 irq on when enabled", 32'(irq), 1);
        bus_write(4'hC, 32'h0000_0011, e);
        #1 check("R9 irq stays with tx reset bit", 32'(irq), 1);
        bus_write(4'hC, 32'h0, e);
        #1 check("R9 irq off after disable", 32'(irq), 0);
    endtask

    task automatic t_tx();
        logic [31:0] d;
        logic e;
        do_reset();
        bus_read(4'h8, d); check("R12 pending clear after reset", d, 32'h4);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'h4; bus_wdata = 32'h1234_56A5;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        #1 check("R10 strobe", 32'(tx_strobe), 1);
        check("R10 byte", 32'(tx_byte), 32'hA5);
        @(negedge clk);
        #1 check("R10 strobe one cycle", 32'(tx_strobe), 0);
        bus_read(4'h4, d); check("R10 tx readback", d, 32'h1234_56A5);
        bus_read(4'h8, d); check("R8 pending set by tx", d, 32'h14);
        bus_write(4'hC, 32'h0000_0013, e);
        bus_write(4'h8, 32'hFFFF_FFFF, e);
        check("R11 bus_err", 32'(e), 1);
        bus_read(4'h8, d); check("R11 status unchanged", d, 32'h14);
        bus_read(4'hC, d); check("R11 ctrl unchanged", d, 32'h13);
        bus_write(4'hC, 32'h0, e);
        check("R11 no err on ctrl", 32'(e), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        t_reset();
        t_order();
        t_full();
        t_simul();
        t_flush();
        t_irq();
        t_tx();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule